// File: doc/BRIEF.md
# Glitch Step Output Classifier

This block models how a four-input, one-output Boolean gate behaves when its inputs do not all change at the same moment. It is given the gate's truth table, the input vector before the clock edge, the input vector after it, and an arrival rank for each input. It then replays the change in four ordered steps. At each step the inputs holding that rank switch to their new value and the rest hold. The gate output is evaluated before and after every step. Each step is placed in one of four classes (output stayed 0, rose, fell, stayed 1).

A run begins with a start pulse while the block is idle. It takes one step per clock. Each step is reported on a class strobe, and four per-class counters collect the results. A one-cycle done pulse marks the end of the run. When every input carries the same rank, the run reduces to the single old-to-new output change. Rank patterns that split the inputs expose the extra intermediate output toggles that a glitch-aware power model needs.

Top module: `glitch_step_tally`

## Requirements
- R1: After reset, `done`, `step_vld` and `busy` are low and all four counts are zero.
- R2: A `start` seen high at a clock edge while `busy` is low latches `truth_tbl`, `old_in`, `new_in` and `rank_vec`. `busy` goes high. Steps 1 to 4 are then reported with `step_vld` high in the 1st to 4th cycles after that edge.
- R3: The snapshot begins at `old_in`. At step i, every input whose rank equals i takes its `new_in` value and all others keep their value. A rank of 0 or above 4 counts as rank 4. After step 4 the snapshot equals `new_in`.
- R4: The gate output for snapshot v is `truth_tbl[v]`, with v = {x1,x2,x3,x4} and x1 in bit 3 of `old_in`/`new_in`. The rank of input bit j is `rank_vec[3j+2:3j]`. `step_cls` is {output before step, output after step}.
- R5: Counter `cnt_00`, `cnt_01`, `cnt_10` or `cnt_11` counts the steps of its class in the run. The four counts sum to 4 at `done`.
- R6: A step at which no input has that rank is classed 00 or 11, according to the unchanged output.
- R7: When all four ranks are equal, `cnt_01 + cnt_10` is 1 if `truth_tbl[old_in]` differs from `truth_tbl[new_in]`, and 0 otherwise.
- R8: `done` is high for exactly one cycle, which is the same cycle as the fourth `step_vld`. The counts then hold until the next accepted start clears them.
- R9: A `start` raised while `busy` is high is ignored. The run in progress completes with its latched inputs.
- R10: A `start` raised in the `done` cycle is accepted and begins a new run with no idle cycle between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run when idle |
| truth_tbl | input | 16 | Gate truth table, bit v is output for input vector v |
| old_in | input | 4 | Input vector before the edge, x1 in bit 3 |
| new_in | input | 4 | Input vector after the edge |
| rank_vec | input | 12 | Arrival rank per input, 3 bits each, input bit j at [3j+2:3j] |
| busy | output | 1 | Run in progress |
| step_vld | output | 1 | One step reported this cycle |
| step_cls | output | 2 | Class of the reported step, {before,after} |
| done | output | 1 | One-cycle end-of-run pulse |
| cnt_00 | output | 3 | Steps with output 0 then 0 |
| cnt_01 | output | 3 | Steps with output 0 then 1 |
| cnt_10 | output | 3 | Steps with output 1 then 0 |
| cnt_11 | output | 3 | Steps with output 1 then 1 |

## Verification
The end-of-run pulse and the acceptance of a new start can fall in the same cycle. The sweep provokes this on half of its runs by raising `start` with fresh operands exactly when `done` is high. It then judges the new run by its per-step classes and counts, which must match a model that restarts from zero. A second collision, a start raised while steps are still running, is provoked on a subset of runs with altered operands. The bench confirms at the ports that the reported classes still follow the originally latched vectors.

// File: rtl/gst_pkg.sv
package gst_pkg;
  // step class code: {output before step, output after step}
  typedef enum logic [1:0] {
    CLS_STAY0 = 2'b00,
    CLS_RISE  = 2'b01,
    CLS_FALL  = 2'b10,
    CLS_STAY1 = 2'b11
  } step_cls_e;

  localparam int unsigned NUM_CLS = 4;
endpackage

// File: rtl/gst_snap_merge.sv
module gst_snap_merge #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned RANK_W = $clog2(N_IN + 1)
) (
  input  logic [N_IN-1:0]        cur,
  input  logic [N_IN-1:0]        tgt,
  input  logic [N_IN*RANK_W-1:0] ranks,
  input  logic [RANK_W-1:0]      step,
  output logic [N_IN-1:0]        merged
);
  localparam logic [RANK_W-1:0] LAST = RANK_W'(N_IN);

  for (genvar j = 0; j < N_IN; j++) begin : g_bit
    logic [RANK_W-1:0] raw_rank;
    logic [RANK_W-1:0] eff_rank;
    assign raw_rank = ranks[j*RANK_W +: RANK_W];
    // out-of-range ranks switch at the final step (R3)
    assign eff_rank = (raw_rank == '0 || raw_rank > LAST) ? LAST : raw_rank;
    assign merged[j] = (eff_rank == step) ? tgt[j] : cur[j];
  end
endmodule

// File: rtl/gst_tally.sv
module gst_tally #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned CNT_W = $clog2(N_IN + 1)
) (
  input  logic                            clk,
  input  logic                            arst_n,
  input  logic                            clr,
  input  logic                            inc_en,
  input  logic [1:0]                      cls,
  output logic [gst_pkg::NUM_CLS*CNT_W-1:0] cnt_flat
);
  localparam int unsigned NC = gst_pkg::NUM_CLS;

  for (genvar c = 0; c < NC; c++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (clr)
        cnt_d = '0;
      else if (inc_en && cls == 2'(c))
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
        cnt_q <= '0;
      else if (clr || inc_en)
        cnt_q <= cnt_d;
    end

    assign cnt_flat[c*CNT_W +: CNT_W] = cnt_q;
  end

  logic [CNT_W+1:0] total;
  always_comb begin
    total = '0;
    for (int c = 0; c < NC; c++)
      total = total + (CNT_W+2)'(cnt_flat[c*CNT_W +: CNT_W]);
  end

  // R5: each classified step adds exactly one unit in total
  a_r5_one_unit_per_step: assert property (@(posedge clk) disable iff (!arst_n)
    inc_en && !clr |=> total == $past(total) + (CNT_W+2)'(1));

  // R2: a cleared tally starts from zero
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!arst_n)
    clr |=> total == '0);
endmodule

// File: rtl/glitch_step_tally.sv
module glitch_step_tally #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned RANK_W = $clog2(N_IN + 1),
  parameter int unsigned CNT_W  = $clog2(N_IN + 1),
  parameter int unsigned TT_W   = 1 << N_IN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [TT_W-1:0]          truth_tbl,
  input  logic [N_IN-1:0]          old_in,
  input  logic [N_IN-1:0]          new_in,
  input  logic [N_IN*RANK_W-1:0]   rank_vec,
  output logic                     busy,
  output logic                     step_vld,
  output logic [1:0]               step_cls,
  output logic                     done,
  output logic [CNT_W-1:0]         cnt_00,
  output logic [CNT_W-1:0]         cnt_01,
  output logic [CNT_W-1:0]         cnt_10,
  output logic [CNT_W-1:0]         cnt_11
);
  localparam logic [RANK_W-1:0] LAST = RANK_W'(N_IN);
  localparam int unsigned       NC   = gst_pkg::NUM_CLS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  // state
  logic                   busy_q, busy_d;
  logic [RANK_W-1:0]      idx_q, idx_d;
  logic [N_IN-1:0]        snap_q, snap_d;
  logic [TT_W-1:0]        tt_q, tt_d;
  logic [N_IN-1:0]        new_q, new_d;
  logic [N_IN*RANK_W-1:0] rank_q, rank_d;
  logic                   vld_q, vld_d;
  logic [1:0]             cls_q, cls_d;
  logic                   done_q, done_d;

  logic                   accept;
  logic                   load_en;
  logic [N_IN-1:0]        merged;
  logic [1:0]             cls_now;
  logic [NC*CNT_W-1:0]    cnt_flat;

  gst_snap_merge #(.N_IN(N_IN), .RANK_W(RANK_W)) u_merge (
    .cur    (snap_q),
    .tgt    (new_q),
    .ranks  (rank_q),
    .step   (idx_q),
    .merged (merged)
  );

  assign accept  = start && !busy_q;
  assign load_en = accept || busy_q;
  assign cls_now = {tt_q[snap_q], tt_q[merged]};

  // next state
  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    snap_d = snap_q;
    tt_d   = tt_q;
    new_d  = new_q;
    rank_d = rank_q;
    cls_d  = cls_q;
    vld_d  = 1'b0;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = RANK_W'(1);
      snap_d = old_in;
      tt_d   = truth_tbl;
      new_d  = new_in;
      rank_d = rank_vec;
    end else if (busy_q) begin
      snap_d = merged;
      vld_d  = 1'b1;
      cls_d  = cls_now;
      idx_d  = idx_q + RANK_W'(1);
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      vld_q  <= vld_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      idx_q  <= '0;
      snap_q <= '0;
      tt_q   <= '0;
      new_q  <= '0;
      rank_q <= '0;
      cls_q  <= '0;
    end else if (load_en) begin
      idx_q  <= idx_d;
      snap_q <= snap_d;
      tt_q   <= tt_d;
      new_q  <= new_d;
      rank_q <= rank_d;
      cls_q  <= cls_d;
    end
  end

  gst_tally #(.N_IN(N_IN), .CNT_W(CNT_W)) u_tally (
    .clk      (clk),
    .arst_n   (arst_n),
    .clr      (accept),
    .inc_en   (busy_q),
    .cls      (cls_now),
    .cnt_flat (cnt_flat)
  );

  assign busy     = busy_q;
  assign step_vld = vld_q;
  assign step_cls = cls_q;
  assign done     = done_q;
  assign cnt_00   = cnt_flat[0*CNT_W +: CNT_W];
  assign cnt_01   = cnt_flat[1*CNT_W +: CNT_W];
  assign cnt_10   = cnt_flat[2*CNT_W +: CNT_W];
  assign cnt_11   = cnt_flat[3*CNT_W +: CNT_W];

  // R3: the walk ends on the new input vector
  a_r3_ends_on_new: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |-> snap_q == new_q);

  // R5: counts sum to the step count at the end of a run
  a_r5_sum_at_done: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |-> (CNT_W+2)'(cnt_00) + (CNT_W+2)'(cnt_01) + (CNT_W+2)'(cnt_10)
               + (CNT_W+2)'(cnt_11) == (CNT_W+2)'(N_IN));

  // R4: consecutive steps chain, before of one equals after of the previous
  a_r4_step_chain: assert property (@(posedge clk) disable iff (!arst_n)
    step_vld && $past(step_vld) |-> step_cls[1] == $past(step_cls[0]));

  // R8: done is a single-cycle pulse that coincides with a step report
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |=> !done_q);
  a_r8_done_with_step: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |-> step_vld);

  // R9: latched operands do not move during a run
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!arst_n)
    busy_q |=> $stable(tt_q) && $stable(new_q) && $stable(rank_q));
endmodule

// File: tb/glitch_step_tally_bench.sv
module glitch_step_tally_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] truth_tbl;
  logic [3:0]  old_in, new_in;
  logic [11:0] rank_vec;
  logic        busy, step_vld, done;
  logic [1:0]  step_cls;
  logic [2:0]  cnt_00, cnt_01, cnt_10, cnt_11;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  glitch_step_tally u_glitch_step_tally (
    .clk(clk), .rst_n(rst_n), .start(start), .truth_tbl(truth_tbl),
    .old_in(old_in), .new_in(new_in), .rank_vec(rank_vec),
    .busy(busy), .step_vld(step_vld), .step_cls(step_cls), .done(done),
    .cnt_00(cnt_00), .cnt_01(cnt_01), .cnt_10(cnt_10), .cnt_11(cnt_11)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] table_of(input int t);
    logic [15:0] v;
    v = '0;
    case (t)
      0: v = 16'h8000;
      1: v = 16'hFFFE;
      2: v = 16'h6996;
      3: for (int i = 0; i < 16; i++)   // second share of a masked product
           v[i] = i[3] ^ i[1] ^ ((i[3] ^ i[2]) & (i[1] ^ i[0]));
      4: for (int i = 0; i < 16; i++) v[i] = i[3] ^ i[1];
      default: v = 16'h0F35;
    endcase
    return v;
  endfunction

  function automatic logic [11:0] ranks_of(input int p);
    logic [11:0] rv;
    int r;
    rv = '0;
    for (int j = 0; j < 4; j++) begin
      case (p)
        0, 1, 2, 3: r = p + 1;
        4: r = j + 1;
        5: r = 4 - j;
        6: r = (j < 2) ? 1 : 3;
        default: r = (j == 0) ? 0 : ((j == 1) ? 2 : ((j == 2) ? 4 : 2));
      endcase
      rv[j*3 +: 3] = 3'(r);
    end
    return rv;
  endfunction

  task automatic run_vec(input logic [15:0] tt, input logic [3:0] o, input logic [3:0] n,
                         input int p, input bit ign, input bit b2b);
    logic [11:0] rk;
    logic [3:0]  s, nx;
    logic [1:0]  ecls [1:4];
    int          ec [4];
    int          r;
    rk = ranks_of(p);
    for (int c = 0; c < 4; c++) ec[c] = 0;
    s = o;
    for (int i = 1; i <= 4; i++) begin
      nx = s;
      for (int j = 0; j < 4; j++) begin
        r = int'(rk[j*3 +: 3]);
        if (r < 1 || r > 4) r = 4;
        if (r == i) nx[j] = n[j];
      end
      ecls[i] = {tt[s], tt[nx]};
      ec[{tt[s], tt[nx]}]++;
      s = nx;
    end
    start = 1'b1; truth_tbl = tt; old_in = o; new_in = n; rank_vec = rk;
    @(negedge clk);
    start = ign;
    truth_tbl = ~tt; old_in = ~o; new_in = ~n; rank_vec = ~rk;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k >= 2) start = 1'b0;
      // R2 R4 (R3 through the snapshot order, R9 when ign)
      chk(step_vld === 1'b1 && step_cls === ecls[k], ign ? "R9 step class" : "R4 step class",
          {step_vld, step_cls}, {1'b1, ecls[k]});
      if (k == 4) begin
        chk(done === 1'b1, "R8 done with last step", done, 1);
        chk(cnt_00 == 3'(ec[0]) && cnt_01 == 3'(ec[1]) && cnt_10 == 3'(ec[2]) && cnt_11 == 3'(ec[3]),
            "R5 counts", {cnt_00, cnt_01, cnt_10, cnt_11},
            {3'(ec[0]), 3'(ec[1]), 3'(ec[2]), 3'(ec[3])});
        if (p < 4)
          chk(int'(cnt_01) + int'(cnt_10) == int'(tt[o] != tt[n]), "R7 single change",
              int'(cnt_01) + int'(cnt_10), int'(tt[o] != tt[n]));
        if (p == 6)   // ranks 2 and 4 unused: steps 2 and 4 do not toggle
          chk(ecls[2][1] == ecls[2][0] && ecls[4][1] == ecls[4][0] && cnt_01 + cnt_10 <= 3'd2,
              "R6 empty rank steps", {cnt_01, cnt_10}, 0);
      end
    end
    if (!b2b) begin
      @(negedge clk);
      chk(done === 1'b0 && step_vld === 1'b0 && busy === 1'b0 &&
          cnt_00 == 3'(ec[0]) && cnt_11 == 3'(ec[3]) && cnt_01 == 3'(ec[1]) && cnt_10 == 3'(ec[2]),
          "R8 hold after done", {done, step_vld, busy}, 0);
    end
  endtask

  initial begin
    #1_900_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; truth_tbl = '0; old_in = '0; new_in = '0; rank_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(done === 1'b0 && step_vld === 1'b0 && busy === 1'b0, "R1 reset flags",
        {done, step_vld, busy}, 0);
    chk(cnt_00 == 0 && cnt_01 == 0 && cnt_10 == 0 && cnt_11 == 0, "R1 reset counts",
        {cnt_00, cnt_01, cnt_10, cnt_11}, 0);
    for (int t = 0; t < 6; t++)
      for (int o = 0; o < 16; o++)
        for (int n = 0; n < 16; n++)
          for (int p = 0; p < 8; p++)
            // b2b exercises R10: start raised in the done cycle
            run_vec(table_of(t), 4'(o), 4'(n), p, (p == 4 || p == 7) && n[1], n[0] ^ p[0]);
    @(negedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10 idle after last run", {busy, done}, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule